// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block drives the select and strobe pins of an external 8-bit asynchronous device, typically a NAND flash. A host hands it one access at a time as a single-cycle request with a direction, a small address and a write byte. The block then steps through three timed phases: setup, strobe and hold. Read and write accesses have separate counts for each phase, and all counts are decoded from one 32-bit timing word.

When an access reverses the direction of the one before it, the block first inserts a turnaround gap of idle cycles. In flash mode, two address bits of the request become the command-latch and address-latch enables for the whole access. The device's ready/busy pin is brought into the clock domain and presented as a ready flag.

The host sees a busy flag while an access (including any turnaround) is in progress. A one-cycle done pulse marks the final cycle, and on reads the captured byte is valid on that pulse.

Top module: `amem_strobe_seq`

## Requirements
- R1: While and right after reset, cs_n, oe_n and we_n are high, busy, done, bus_doe, cle and ale are low, and the first accepted access carries no turnaround gap.
- R2: The timing word fields are as follows. Write setup is bits 29:26, write strobe 25:20 and write hold 19:17. Read setup is 16:13, read strobe 12:7 and read hold 6:4. Turnaround is 3:2. Every phase lasts its field value plus one clock.
- R3: cs_n is low in one unbroken run, from the first setup cycle to the last hold cycle. That run is setup+strobe+hold+3 cycles long.
- R4: A read pulls oe_n low, and a write pulls we_n low, only during the strobe phase, which begins setup+1 cycles after cs_n falls. The strobe of the other direction stays high.
- R5: During a write, bus_doe is high and bus_dout carries the request byte for every cycle cs_n is low. During a read, bus_doe stays low.
- R6: A read captures bus_din at the clock edge that ends the last strobe cycle. The byte is shown on rd_data in the cycle where done is high.
- R7: An access whose direction differs from the previous access is preceded by turnaround+1 idle busy cycles with cs_n high. An access in the same direction as the previous one gets no gap.
- R8: busy rises in the cycle after a request is accepted in idle and stays high until the cycle of done. done is a single-cycle pulse in the last hold cycle, and requests made while busy are dropped.
- R9: With nand_mode high, cle equals address bit CLE_BIT and ale equals address bit ALE_BIT of the accepted request while cs_n is low. Otherwise both are low.
- R10: The timing word is sampled when the request is accepted. Later changes to it do not affect that access.
- R11: Bits 31, 30, 1 and 0 of the timing word have no effect on any phase length.
- R12: flash_ready follows rb_pin after SYNC_STAGES clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timing_word | input | 32 | Phase-length word, sampled at acceptance |
| nand_mode | input | 1 | Enables latch-enable generation from the address |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Request address; carries the latch-enable bits |
| req_wdata | input | DATA_W | Write byte |
| busy | output | 1 | Access or turnaround in progress |
| done | output | 1 | Last cycle of the access |
| rd_data | output | DATA_W | Captured read byte |
| cs_n | output | 1 | Device select, active low |
| oe_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| bus_dout | output | DATA_W | Data driven to the device |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | DATA_W | Data returned from the device |
| rb_pin | input | 1 | Device ready/busy pin |
| flash_ready | output | 1 | Synchronized ready flag |

## Verification
The bench moves bus_din on every strobe cycle. A design that captures read data one cycle early or late therefore returns the wrong byte instead of one that happens to match. The tests cover:
- the all-zero timing word, where every phase is one cycle and an off-by-one counter collapses or stretches a phase;
- the all-ones fields, which expose truncated field widths;
- alternating and repeated directions, so that a gap added on every access, or never added, shows up as a wrong busy length.

The timing word is scrambled in mid-access, reserved bits are set, and requests are raised while busy. A design that reads the word live, decodes reserved bits, or accepts requests while busy then shows wrong phase lengths or a second access.

// File: rtl/amem_pkg.sv
package amem_pkg;

   // common counter width, wide enough for the largest field
   localparam int CNT_W     = 6;

   // field widths
   localparam int SETUP_W   = 4;
   localparam int STROBE_W  = 6;
   localparam int HOLD_W    = 3;
   localparam int TURN_W    = 2;

   // field positions inside the timing word
   localparam int WR_SETUP_LSB  = 26;
   localparam int WR_STROBE_LSB = 20;
   localparam int WR_HOLD_LSB   = 17;
   localparam int RD_SETUP_LSB  = 13;
   localparam int RD_STROBE_LSB = 7;
   localparam int RD_HOLD_LSB   = 4;
   localparam int TURN_LSB      = 2;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_TURN,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD
   } amem_phase_e;

   typedef struct packed {
      logic [CNT_W-1:0] setup;
      logic [CNT_W-1:0] strobe;
      logic [CNT_W-1:0] hold;
      logic [CNT_W-1:0] turn;
   } amem_tmg_t;

endpackage

// File: rtl/amem_cfg_decode.sv
module amem_cfg_decode
   import amem_pkg::*;
(
   input  logic [31:0] cfg,
   input  logic        is_write,
   output amem_tmg_t   tmg
);

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{cfg[31:30], cfg[1:0]};

   always_comb begin
      tmg = '0;
      tmg.turn[TURN_W-1:0] = cfg[TURN_LSB +: TURN_W];
      if (is_write) begin
         tmg.setup[SETUP_W-1:0]   = cfg[WR_SETUP_LSB  +: SETUP_W];
         tmg.strobe[STROBE_W-1:0] = cfg[WR_STROBE_LSB +: STROBE_W];
         tmg.hold[HOLD_W-1:0]     = cfg[WR_HOLD_LSB   +: HOLD_W];
      end else begin
         tmg.setup[SETUP_W-1:0]   = cfg[RD_SETUP_LSB  +: SETUP_W];
         tmg.strobe[STROBE_W-1:0] = cfg[RD_STROBE_LSB +: STROBE_W];
         tmg.hold[HOLD_W-1:0]     = cfg[RD_HOLD_LSB   +: HOLD_W];
      end
   end

endmodule

// File: rtl/amem_phase_ctrl.sv
module amem_phase_ctrl
   import amem_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  amem_tmg_t         tmg_in,
   output amem_phase_e       phase,
   output logic              dir_write,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              last_strobe,
   output logic              last_hold
);

   amem_phase_e      ph_q;
   logic [CNT_W-1:0] cnt_q;
   amem_tmg_t        tm_q;
   logic             have_prev_q;
   logic             prev_dir_q;
   logic             cnt_zero;

   assign cnt_zero    = (cnt_q == '0);
   assign phase       = ph_q;
   assign last_strobe = (ph_q == PH_STROBE) && cnt_zero;
   assign last_hold   = (ph_q == PH_HOLD) && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q        <= PH_IDLE;
         cnt_q       <= '0;
         tm_q        <= '0;
         have_prev_q <= 1'b0;
         prev_dir_q  <= 1'b0;
         dir_write   <= 1'b0;
         addr_q      <= '0;
         wdata_q     <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               if (req_valid) begin
                  dir_write <= req_write;
                  addr_q    <= req_addr;
                  wdata_q   <= req_wdata;
                  tm_q      <= tmg_in;
                  if (have_prev_q && (prev_dir_q != req_write)) begin
                     ph_q  <= PH_TURN;
                     cnt_q <= tmg_in.turn;
                  end else begin
                     ph_q  <= PH_SETUP;
                     cnt_q <= tmg_in.setup;
                  end
               end
            end
            PH_TURN: begin
               if (cnt_zero) begin
                  ph_q  <= PH_SETUP;
                  cnt_q <= tm_q.setup;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_SETUP: begin
               if (cnt_zero) begin
                  ph_q  <= PH_STROBE;
                  cnt_q <= tm_q.strobe;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_STROBE: begin
               if (cnt_zero) begin
                  ph_q  <= PH_HOLD;
                  cnt_q <= tm_q.hold;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt_zero) begin
                  ph_q        <= PH_IDLE;
                  have_prev_q <= 1'b1;
                  prev_dir_q  <= dir_write;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/amem_rb_sync.sv
module amem_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level
);

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign level = chain_q[STAGES-1];

endmodule

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq
   import amem_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int CLE_BIT     = 1,
   parameter int ALE_BIT     = 2,
   parameter bit NAND_EN     = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       timing_word,
   input  logic              nand_mode,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              cs_n,
   output logic              oe_n,
   output logic              we_n,
   output logic              cle,
   output logic              ale,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              rb_pin,
   output logic              flash_ready
);

   if (DATA_W != 8) begin : g_bad_data
      $error("amem_strobe_seq: only an 8-bit device bus is supported");
   end
   if (CLE_BIT >= ADDR_W || ALE_BIT >= ADDR_W || CLE_BIT == ALE_BIT) begin : g_bad_latch
      $error("amem_strobe_seq: latch-enable bits must be distinct and inside the address");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("amem_strobe_seq: at least two synchronizer stages are required");
   end

   amem_tmg_t         tmg;
   amem_phase_e       phase;
   logic              dir_write;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              last_strobe;
   logic              last_hold;
   logic              sel_active;
   logic              strobe_active;
   logic [DATA_W-1:0] rd_q;

   amem_cfg_decode u_dec (
      .cfg      (timing_word),
      .is_write (req_write),
      .tmg      (tmg)
   );

   amem_phase_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .tmg_in      (tmg),
      .phase       (phase),
      .dir_write   (dir_write),
      .addr_q      (addr_q),
      .wdata_q     (wdata_q),
      .last_strobe (last_strobe),
      .last_hold   (last_hold)
   );

   amem_rb_sync #(
      .STAGES (SYNC_STAGES)
   ) u_rb (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (rb_pin),
      .level (flash_ready)
   );

   assign sel_active    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
   assign strobe_active = (phase == PH_STROBE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        rd_q <= '0;
      else if (last_strobe && !dir_write) rd_q <= bus_din;
   end

   assign busy     = (phase != PH_IDLE);
   assign done     = last_hold;
   assign rd_data  = rd_q;
   assign cs_n     = !sel_active;
   assign oe_n     = !(strobe_active && !dir_write);
   assign we_n     = !(strobe_active && dir_write);
   assign bus_doe  = sel_active && dir_write;
   assign bus_dout = wdata_q;

   if (NAND_EN) begin : g_latch
      assign cle = nand_mode && sel_active && addr_q[CLE_BIT];
      assign ale = nand_mode && sel_active && addr_q[ALE_BIT];
   end else begin : g_no_latch
      logic unused_latch;
      assign unused_latch = nand_mode;
      assign cle = 1'b0;
      assign ale = 1'b0;
   end

endmodule

// File: rtl/amem_strobe_seq_chk.sv
module amem_strobe_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic done,
   input logic cs_n,
   input logic oe_n,
   input logic we_n,
   input logic bus_doe,
   input logic cle,
   input logic ale,
   input logic nand_mode
);

   // R3
   sel_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   // R4
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));

   // R4
   strobe_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n || !we_n) |-> !cs_n);

   // R5
   wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> bus_doe);

   // R5
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !bus_doe);

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   // R8
   done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R9
   latch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_mode |-> (!cle && !ale));

   // R9
   latch_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cle || ale) |-> !cs_n);

endmodule

bind amem_strobe_seq amem_strobe_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .cs_n      (cs_n),
   .oe_n      (oe_n),
   .we_n      (we_n),
   .bus_doe   (bus_doe),
   .cle       (cle),
   .ale       (ale),
   .nand_mode (nand_mode)
);

// File: tb/tb_amem_strobe_seq.sv
module tb_amem_strobe_seq;

   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [31:0]       timing_word = '0;
   logic              nand_mode = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              busy, done, cs_n, oe_n, we_n, cle, ale, bus_doe, flash_ready;
   logic [DATA_W-1:0] rd_data, bus_dout;
   logic [DATA_W-1:0] bus_din = '0;
   logic              rb_pin = 1'b0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   amem_strobe_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .timing_word(timing_word), .nand_mode(nand_mode),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
      .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .cle(cle), .ale(ale),
      .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
      .rb_pin(rb_pin), .flash_ready(flash_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_cfg(int ws, int wst, int wh, int rs, int rst, int rh, int ta);
      logic [31:0] w;
      w = '0;
      w[29:26] = 4'(ws);
      w[25:20] = 6'(wst);
      w[19:17] = 3'(wh);
      w[16:13] = 4'(rs);
      w[12:7]  = 6'(rst);
      w[6:4]   = 3'(rh);
      w[3:2]   = 2'(ta);
      return w;
   endfunction

   // One access: drive request, watch it to completion, compare with expectations
   task automatic do_acc(input bit wr, input logic [3:0] a, input logic [7:0] d,
                         input bit nm, input logic [31:0] cfg, input bit disturb,
                         input int exp_gap, input int s, input int t, input int h,
                         input string tag);
      int cyc = 0, first_cs = -1, first_st = -1, ncs = 0, nst = 0, ndone = 0;
      int bad_pin = 0, bad_other = 0, bad_latch = 0;
      int rd_seen = -1;
      bit exp_cle, exp_ale;
      exp_cle = nm && a[1];
      exp_ale = nm && a[2];
      @(negedge clk);
      timing_word = cfg; nand_mode = nm;
      req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (disturb) timing_word = ~cfg;
      while (busy && cyc < 2000) begin
         if (disturb) begin
            req_valid = (cyc >= 1 && cyc < 4);
            req_write = ~wr;
         end
         if (!cs_n) begin
            if (first_cs < 0) first_cs = cyc;
            ncs++;
            if (cle !== exp_cle || ale !== exp_ale) bad_latch++;
            if (wr) begin
               if (bus_doe !== 1'b1 || bus_dout !== d) bad_pin++;
            end else if (bus_doe !== 1'b0) bad_pin++;
         end else if (cle || ale) bad_latch++;
         if ((wr ? we_n : oe_n) == 1'b0) begin
            if (first_st < 0) first_st = cyc;
            if (!wr) bus_din = d + 8'(nst);
            nst++;
         end
         if ((wr ? oe_n : we_n) == 1'b0) bad_other++;
         if (done) begin
            ndone++;
            rd_seen = int'(rd_data);
         end
         @(negedge clk);
         cyc++;
      end
      req_valid = 1'b0;
      // R8 / R7 / R3: busy length covers gap plus three phases
      chk(cyc == exp_gap + s + t + h + 3, {"R8 busy length ", tag}, cyc, exp_gap + s + t + h + 3);
      // R7 gap before select
      chk(first_cs == exp_gap, {"R7 turnaround gap ", tag}, first_cs, exp_gap);
      // R3 select length (R2 field decode)
      chk(ncs == s + t + h + 3, {"R3 R2 select length ", tag}, ncs, s + t + h + 3);
      // R4 strobe start and length
      chk(first_st - first_cs == s + 1, {"R4 R2 strobe offset ", tag}, first_st - first_cs, s + 1);
      chk(nst == t + 1, {"R4 R2 strobe length ", tag}, nst, t + 1);
      chk(bad_other == 0, {"R4 wrong strobe low ", tag}, bad_other, 0);
      // R5 bus drive
      chk(bad_pin == 0, {"R5 data bus ", tag}, bad_pin, 0);
      // R9 latch enables
      chk(bad_latch == 0, {"R9 latch enables ", tag}, bad_latch, 0);
      // R8 single done
      chk(ndone == 1, {"R8 done pulses ", tag}, ndone, 1);
      if (!wr) begin
         // R6 last-strobe capture
         chk(rd_seen == int'(8'(d + 8'(t))), {"R6 read capture ", tag}, rd_seen, int'(8'(d + 8'(t))));
      end
      if (disturb) begin
         // R8 no second access from requests raised while busy
         repeat (3) begin
            chk(busy == 1'b0 && cs_n == 1'b1, {"R8 request while busy ", tag}, int'(busy), 0);
            @(negedge clk);
         end
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      // R1
      chk(cs_n && oe_n && we_n, "R1 strobes high in reset", int'({cs_n, oe_n, we_n}), 7);
      chk(!busy && !done && !bus_doe && !cle && !ale, "R1 flags low in reset",
          int'({busy, done, bus_doe, cle, ale}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n && !busy, "R1 idle after reset", int'({cs_n, busy}), 2);
   endtask

   task automatic t_rb_sync();
      @(negedge clk);
      rb_pin = 1'b1;
      @(negedge clk);
      // R12 not yet through after one edge
      chk(flash_ready == 1'b0, "R12 ready after one edge", int'(flash_ready), 0);
      @(negedge clk);
      chk(flash_ready == 1'b1, "R12 ready after two edges", int'(flash_ready), 1);
      rb_pin = 1'b0;
      repeat (2) @(negedge clk);
      chk(flash_ready == 1'b0, "R12 busy after two edges", int'(flash_ready), 0);
   endtask

   initial begin
      logic [31:0] dflt, zero_w, max_w;
      dflt   = mk_cfg(1, 3, 1, 1, 5, 1, 3);
      zero_w = mk_cfg(0, 0, 0, 0, 0, 0, 0);
      max_w  = mk_cfg(15, 63, 7, 15, 63, 7, 3);
      t_reset();
      // R1 first access: no gap; R2 default write timing
      do_acc(1'b1, 4'h0, 8'hA5, 1'b0, dflt, 1'b0, 0, 1, 3, 1, "first write");
      // R7 direction change
      do_acc(1'b0, 4'h0, 8'h30, 1'b0, dflt, 1'b0, 4, 1, 5, 1, "read after write");
      // R7 same direction
      do_acc(1'b0, 4'h0, 8'h50, 1'b0, dflt, 1'b0, 0, 1, 5, 1, "read after read");
      // R2 all-zero fields
      do_acc(1'b1, 4'h0, 8'h3C, 1'b0, zero_w, 1'b0, 1, 0, 0, 0, "zero write");
      // R2 full-scale fields
      do_acc(1'b0, 4'h0, 8'h10, 1'b0, max_w, 1'b0, 4, 15, 63, 7, "max read");
      // R11 reserved bits set
      do_acc(1'b1, 4'h0, 8'h99, 1'b0, dflt | 32'hC000_0003, 1'b0, 4, 1, 3, 1, "R11 reserved bits");
      // R10 word scrambled mid-access, R8 requests while busy
      do_acc(1'b1, 4'h0, 8'h66, 1'b0, dflt, 1'b1, 0, 1, 3, 1, "R10 disturbed");
      // R9 command latch (addr bit 1) and address latch (addr bit 2)
      do_acc(1'b1, 4'h2, 8'h70, 1'b1, dflt, 1'b0, 0, 1, 3, 1, "R9 command latch");
      do_acc(1'b1, 4'h4, 8'h00, 1'b1, dflt, 1'b0, 0, 1, 3, 1, "R9 address latch");
      do_acc(1'b1, 4'h6, 8'h12, 1'b0, dflt, 1'b0, 0, 1, 3, 1, "R9 mode off");
      t_rb_sync();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule